// File: doc/BRIEF.md
# SYSREF Pulse Qualifier

This block sits between an asynchronous SYSREF input and the synchronizing logic of a JESD transmit or receive path, and decides which SYSREF events are forwarded. The input is brought into the device clock domain and edge-detected, so a pulse that stays high for several cycles counts as one event. Each event is then either forwarded as a single-cycle strobe or dropped, according to a 3-bit policy code.

The policy code combines two settings. The first is how many leading events to drop: zero, one or two. The second is whether the block then forwards a single event (single-shot) or every later event (continuous). Two codes forward nothing. A register write port loads the code. Every write re-arms the sequence, so that skipping starts again from zero and a finished single-shot can fire once more. A done flag shows that a single-shot policy has forwarded its event.

Top module: `sysref_qualifier`

## Requirements
- R1: After synchronous active-low reset the policy code is 001 (forward every event), and `sref_strobe` and `oneshot_done` are low.
- R2: With code 001, every rising event on `sref_in` produces exactly one `sref_strobe` cycle. The strobe is high in the third clock cycle after the first rising edge that samples `sref_in` high. This holds however long the input stays high.
- R3: With code 000 or code 111, no event ever produces a strobe.
- R4: With code 010, the first event after arming is forwarded and all later events are dropped.
- R5: With code 011, the first event after arming is dropped, the second is forwarded, and all later events are dropped.
- R6: With code 100, the first event after arming is dropped and every later event is forwarded.
- R7: With code 101, the first two events after arming are dropped, the third is forwarded, and all later events are dropped.
- R8: With code 110, the first two events after arming are dropped and every later event is forwarded.
- R9: A cycle with `cfg_wr_en` high loads `cfg_wr_mode` and re-arms the block. The dropped-event count returns to zero and `oneshot_done` goes low, even when the same code is written again.
- R10: `oneshot_done` rises with the strobe of a single-shot code (010, 011, 101) and stays high until the next write. It never rises under a continuous code or a code that forwards nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sref_in | input | 1 | Raw SYSREF, asynchronous to clk |
| cfg_wr_en | input | 1 | Write strobe for the policy code |
| cfg_wr_mode | input | 3 | Policy code to load |
| sref_strobe | output | 1 | Qualified single-cycle SYSREF strobe |
| oneshot_done | output | 1 | Single-shot policy has forwarded its event |

## Verification
The assertions assume that `sref_in` stays low for at least one clock between events, so that the edge detector cannot report two rises in adjacent cycles. They also assume that a write is never issued in the cycle that an event is being qualified. The stimulus keeps every pulse at least one cycle wide, holds the input low for eight cycles between pulses, and issues each policy write only while the input has been low for some cycles. The dropped-event counter and the done flag are therefore always judged against a settled code.

// File: rtl/sysref_qual_pkg.sv
// Shared types for the SYSREF qualifier: the policy code layout and its
// decoding into an enable, a skip count and a single-shot choice.
// Assumes the policy code is always 3 bits wide.
package sysref_qual_pkg;

    localparam int unsigned MODE_W = 3;
    localparam int unsigned SKIP_W = 2;

    typedef enum logic [MODE_W-1:0] {
        POL_OFF      = 3'b000,
        POL_ALL      = 3'b001,
        POL_ONCE     = 3'b010,
        POL_SKIP1_1  = 3'b011,
        POL_SKIP1_ALL= 3'b100,
        POL_SKIP2_1  = 3'b101,
        POL_SKIP2_ALL= 3'b110,
        POL_RSVD     = 3'b111
    } policy_e;

    typedef struct packed {
        logic              enable;
        logic              single;
        logic [SKIP_W-1:0] skip;
    } policy_cfg_t;

    // Map a policy code to the settings the gate acts on.
    function automatic policy_cfg_t decode_policy(input logic [MODE_W-1:0] code);
        policy_cfg_t c;
        c = '0;
        unique case (code)
            POL_ALL:       begin c.enable = 1'b1; c.single = 1'b0; c.skip = 2'd0; end
            POL_ONCE:      begin c.enable = 1'b1; c.single = 1'b1; c.skip = 2'd0; end
            POL_SKIP1_1:   begin c.enable = 1'b1; c.single = 1'b1; c.skip = 2'd1; end
            POL_SKIP1_ALL: begin c.enable = 1'b1; c.single = 1'b0; c.skip = 2'd1; end
            POL_SKIP2_1:   begin c.enable = 1'b1; c.single = 1'b1; c.skip = 2'd2; end
            POL_SKIP2_ALL: begin c.enable = 1'b1; c.single = 1'b0; c.skip = 2'd2; end
            default:       c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/sysref_sync_edge.sv
// Brings an asynchronous SYSREF level into the clk domain through a
// SYNC_STAGES flop chain, then flags the first cycle the synchronized
// level is seen high. Assumes the input is low for at least one clock
// between events; a long high level yields a single rise.
module sysref_sync_edge #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    localparam int unsigned LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] chain_q;
    logic                   prev_q;

    // Shift the raw input through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[SYNC_STAGES-2:0], async_in};
    end

    // Remember the last synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[LAST];
    end

    // Rise is the first high cycle of the synchronized level.
    always_comb rise = chain_q[LAST] & ~prev_q;

    // Requirement R2: one input event yields a rise of one cycle only.
    p_rise_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/sysref_pulse_gate.sv
// Applies the decoded policy to each detected rise. It counts dropped
// events up to the policy's skip count, forwards one or all further
// events as a registered strobe, and latches a used flag for single-shot
// policies. A re-arm clears both counter and flag and wins over a rise in
// the same cycle. Assumes mode changes only together with rearm.
module sysref_pulse_gate
    import sysref_qual_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise,
    input  logic              rearm,
    input  logic [MODE_W-1:0] mode,
    output logic              strobe,
    output logic              done
);
    policy_cfg_t       cfg;
    logic [SKIP_W-1:0] skip_cnt_q;
    logic              used_q;
    logic              strobe_q;
    logic              skipping;
    logic              forward;

    // Decode the current policy code.
    always_comb cfg = decode_policy(mode);

    // Classify the current rise: still being skipped, or forwarded.
    always_comb begin
        skipping = rise && cfg.enable && (skip_cnt_q < cfg.skip);
        forward  = rise && cfg.enable && !skipping && !(cfg.single && used_q);
    end

    // Skip counter, used flag and registered strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            skip_cnt_q <= '0;
            used_q     <= 1'b0;
            strobe_q   <= 1'b0;
        end else if (rearm) begin
            skip_cnt_q <= '0;
            used_q     <= 1'b0;
            strobe_q   <= 1'b0;
        end else begin
            strobe_q <= forward;
            if (skipping)                skip_cnt_q <= skip_cnt_q + 1'b1;
            if (forward && cfg.single)   used_q     <= 1'b1;
        end
    end

    always_comb begin
        strobe = strobe_q;
        done   = used_q;
    end

    // Requirement R3: a code that forwards nothing, held for two cycles, gives no strobe.
    p_off_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.enable && $past(!decode_policy(mode).enable) && !$past(rearm)) |-> !strobe);

    // Requirement R5: a rise that is being skipped yields no strobe.
    p_skip_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (skipping && !rearm) |=> !strobe);

    // Requirement R10: once the single-shot fired, no further strobe.
    p_single_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !strobe);

    // Requirement R10: the done flag only exists under a single-shot code.
    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cfg.single);

    // Requirement R9: done holds until a re-arm clears it.
    p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !rearm) |=> done);

    // Requirement R9: a re-arm always leaves done low.
    p_rearm_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rearm |=> !done);

endmodule

// File: rtl/sysref_qualifier.sv
// Top of the SYSREF qualifier: holds the policy code register (reset to
// forward-all), re-arms the gate on every write, and chains the
// synchronizer/edge detector into the policy gate. Assumes writes and
// SYSREF events do not coincide when deterministic behaviour is needed.
module sysref_qualifier
    import sysref_qual_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sref_in,
    input  logic              cfg_wr_en,
    input  logic [MODE_W-1:0] cfg_wr_mode,
    output logic              sref_strobe,
    output logic              oneshot_done
);
    logic [MODE_W-1:0] mode_q;
    logic              rise;

    // Policy code register, reset to forward-every-event.
    always_ff @(posedge clk) begin
        if (!rst_n)         mode_q <= POL_ALL;
        else if (cfg_wr_en) mode_q <= cfg_wr_mode;
    end

    sysref_sync_edge #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (sref_in),
        .rise     (rise)
    );

    sysref_pulse_gate u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .rise   (rise),
        .rearm  (cfg_wr_en),
        .mode   (mode_q),
        .strobe (sref_strobe),
        .done   (oneshot_done)
    );

    // Requirement R9: a write lands in the policy register on the next cycle.
    p_write_loads_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_en |=> (mode_q == $past(cfg_wr_mode)));

    // Requirement R2: the qualified strobe is never wider than one cycle.
    p_strobe_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sref_strobe |=> !sref_strobe);

endmodule

// File: tb/tb_sysref_qualifier.sv
module tb_sysref_qualifier;
    localparam int CLK_PERIOD = 10;
    localparam int LATENCY    = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sref_in = 1'b0;
    logic       cfg_wr_en = 1'b0;
    logic [2:0] cfg_wr_mode = 3'b000;
    logic       sref_strobe;
    logic       oneshot_done;

    typedef struct {
        bit    pass;
        bit    done;
        string req;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    int   cyc = 0;
    int   rise_cyc = 0;
    int   strobes = 0;
    int   lat = 0;
    bit   chk_pending = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sysref_qualifier dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .sref_in      (sref_in),
        .cfg_wr_en    (cfg_wr_en),
        .cfg_wr_mode  (cfg_wr_mode),
        .sref_strobe  (sref_strobe),
        .oneshot_done (oneshot_done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Driver: load a policy code (re-arms the block).
    task automatic write_mode(input logic [2:0] m);
        @(negedge clk);
        cfg_wr_en   = 1'b1;
        cfg_wr_mode = m;
        @(negedge clk);
        cfg_wr_en   = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // Driver: push the expectation, drive one event, hand it to the monitor.
    task automatic pulse(input int width, input bit pass, input bit done, input string req);
        exp_t e;
        e.pass = pass; e.done = done; e.req = req;
        exp_q.push_back(e);
        @(negedge clk);
        sref_in  = 1'b1;
        rise_cyc = cyc;
        repeat (width) @(negedge clk);
        sref_in = 1'b0;
        repeat (8) @(negedge clk);
        chk_pending = 1'b1;
        wait (chk_pending == 1'b0);
    endtask

    // Monitor: counts strobes and, when asked, pops and compares an expectation.
    initial begin
        forever begin
            @(negedge clk);
            if (sref_strobe) begin
                strobes++;
                lat = cyc - rise_cyc;
            end
            if (chk_pending) begin
                exp_t e;
                e = exp_q.pop_front();
                check(strobes == (e.pass ? 1 : 0), {e.req, " strobe count"}, strobes, e.pass ? 1 : 0);
                if (e.pass)
                    check(lat == LATENCY, {e.req, " strobe latency"}, lat, LATENCY);
                check(oneshot_done == e.done, {e.req, " done flag"}, oneshot_done, e.done);
                strobes = 0;
                chk_pending = 1'b0;
            end
        end
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check(sref_strobe == 1'b0, "R1 strobe in reset", sref_strobe, 0);
        check(oneshot_done == 1'b0, "R1 done in reset", oneshot_done, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(sref_strobe == 1'b0 && oneshot_done == 1'b0, "R1 outputs after reset",
              {sref_strobe, oneshot_done}, 0);

        // R1/R2: default code forwards every event, long pulse gives one strobe
        pulse(1, 1'b1, 1'b0, "R1 default forwards");
        pulse(5, 1'b1, 1'b0, "R2 long pulse");
        pulse(2, 1'b1, 1'b0, "R2 repeat");

        // R3: codes that forward nothing
        write_mode(3'b000);
        pulse(1, 1'b0, 1'b0, "R3 code 000");
        pulse(3, 1'b0, 1'b0, "R3 code 000 again");
        write_mode(3'b111);
        pulse(1, 1'b0, 1'b0, "R3 code 111");

        // R4: only the first event
        write_mode(3'b010);
        pulse(1, 1'b1, 1'b1, "R4 first");
        pulse(1, 1'b0, 1'b1, "R4 second");
        pulse(2, 1'b0, 1'b1, "R10 done holds");

        // R9: rewrite the same code re-arms
        write_mode(3'b010);
        check(oneshot_done == 1'b0, "R9 done cleared by write", oneshot_done, 0);
        pulse(1, 1'b1, 1'b1, "R9 re-armed single");

        // R5: skip one, forward one
        write_mode(3'b011);
        pulse(1, 1'b0, 1'b0, "R5 skipped");
        pulse(1, 1'b1, 1'b1, "R5 forwarded");
        pulse(1, 1'b0, 1'b1, "R5 blocked");

        // R9: skip counter resets on write
        write_mode(3'b011);
        pulse(1, 1'b0, 1'b0, "R9 skip restarts");
        write_mode(3'b011);
        pulse(1, 1'b0, 1'b0, "R9 skip restarts again");
        pulse(1, 1'b1, 1'b1, "R9 forwarded after restart");

        // R6: skip one, forward all
        write_mode(3'b100);
        pulse(1, 1'b0, 1'b0, "R6 skipped");
        pulse(1, 1'b1, 1'b0, "R6 forwarded");
        pulse(1, 1'b1, 1'b0, "R6 forwarded again");

        // R7: skip two, forward one
        write_mode(3'b101);
        pulse(1, 1'b0, 1'b0, "R7 skip one");
        pulse(1, 1'b0, 1'b0, "R7 skip two");
        pulse(1, 1'b1, 1'b1, "R7 forwarded");
        pulse(1, 1'b0, 1'b1, "R7 blocked");

        // R8: skip two, forward all
        write_mode(3'b110);
        pulse(1, 1'b0, 1'b0, "R8 skip one");
        pulse(4, 1'b0, 1'b0, "R8 skip two");
        pulse(1, 1'b1, 1'b0, "R8 forwarded");
        pulse(1, 1'b1, 1'b0, "R10 continuous no done");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule